// File: doc/BRIEF.md
# Parallel Port Control-Line Handshake Unit

This block runs the control-line side of a two-port parallel interface. Each port has one edge-sensitive input line (C1) and one configurable line (C2). C2 can act as an interrupt input, a handshake output, a pulse output, or a fixed manual level. Port A is index 0 and port B is index 1 on every two-bit port. An 8-bit control register selects the C1 active edge and the C2 mode for each port. The C1 and C2 inputs pass through a synchronizer. An edge flag is set when an input reaches the configured level. Port data accesses and the two clear inputs remove the flags.

C2 is driven by one state machine per port. The state holds both the mode class and the intended C2 level. States: `C2_IN_LO` / `C2_IN_HI` (input mode, level held but not driven), `C2_MAN_LO` / `C2_MAN_HI` (manual level), `C2_HS_LO` / `C2_HS_HI` (handshake), `C2_PL_LO` / `C2_PL_HI` (pulse). Transitions:
- *mode-load*: a control write enters the state for the new code. Manual codes force the level. Every other code keeps the current level.
- *port-access*: any read or write of the port's own data address. It takes `HS_HI→HS_LO` and `PL_HI→PL_LO`.
- *c1-release*: an active C1 edge takes `HS_LO→HS_HI`.
- *pulse-end*: `PL_LO→PL_HI` on the next clock when no access is present.

Top module: `pctl_handshake`

## Requirements
- R1: After reset the control register reads 0x00. All four edge flags are 0, and `c2_oe` and `c2_out` are 0 for both ports.
- R2: A write to address 0xC loads the control register. Bits 3:0 configure port A and bits 7:4 configure port B. A read strobe at 0xC returns the register on `bus_rdata` in the same cycle. Any other address returns 0.
- R3: A change of a port's synchronized C1 sets its C1 flag only when the new level equals nibble bit 0. The flag becomes visible SYNC_STAGES+1 clock edges after the input changes.
- R4: A change of synchronized C2 sets the C2 flag only when nibble bit 3 is 0 and the new level equals nibble bit 2. The latency is the same as in R3.
- R5: Nibble bit 3 drives `c2_oe`. Codes in bits 3:1 of 110 and 111 drive `c2_out` low and high on the edge of the control write.
- R6: Handshake code 100: a read or write of the port's data address (A at 0x1, B at 0x0) drives C2 low. A later active C1 edge drives it high again. When an access and an active C1 edge act on the same edge, C2 goes low.
- R7: Pulse code 101: a data access drives C2 low for exactly one cycle, after which it returns high.
- R8: In input codes the intended level is kept and `c2_out` is 0. A later switch into handshake code shows the kept level.
- R9: A read at the port's data address clears both of its flags. A read at 0xF clears port A's flags without moving port A's C2. Neither read touches the other port's flags.
- R10: A write at the port's data address clears the C1 flag. It also clears the C2 flag, except in codes 001 and 011.
- R11: In independent codes 001 and 011, reads and writes of the data address leave the C2 flag set.
- R12: `c1_clr`/`c2_clr` clear the matching flag. A flag set and any clear on the same edge leave the flag set.
- R13: Writing the same manual code again leaves `c2_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (control register at 0xC) |
| c1_in | input | 2 | C1 input lines, [0]=A, [1]=B |
| c2_in | input | 2 | C2 input lines |
| c2_out | output | 2 | C2 driven level |
| c2_oe | output | 2 | C2 output enable |
| c1_flag | output | 2 | C1 edge flags |
| c2_flag | output | 2 | C2 edge flags |
| c1_clr | input | 2 | Clear strobes for the C1 flags |
| c2_clr | input | 2 | Clear strobes for the C2 flags |

## Verification
Two functions can act on the same clock edge in two ways:
- An active C1 edge reaching the handshake state machine while the processor accesses the port's data register.
- A new edge flag being set while a clear arrives, either from a data read or from a clear strobe.

The bench provokes both by changing an input line and then counting exactly SYNC_STAGES clocks before it raises the strobe. The strobe therefore meets the detected edge on the same edge. The result is judged from the ports: C2 must stay low and the flag must stay set. Around these cases, every nibble value on both ports is swept with both edge directions on C1 and C2.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam logic [3:0] ADR_PB       = 4'h0;
    localparam logic [3:0] ADR_PA       = 4'h1;
    localparam logic [3:0] ADR_CTRL     = 4'hC;
    localparam logic [3:0] ADR_PA_QUIET = 4'hF;

    // bit 0 of the state is the intended C2 level
    typedef enum logic [2:0] {
        C2_IN_LO  = 3'b000,
        C2_IN_HI  = 3'b001,
        C2_MAN_LO = 3'b010,
        C2_MAN_HI = 3'b011,
        C2_HS_LO  = 3'b100,
        C2_HS_HI  = 3'b101,
        C2_PL_LO  = 3'b110,
        C2_PL_HI  = 3'b111
    } c2_state_t;

    // nibble bits 3:1
    typedef enum logic [2:0] {
        MD_IN_NEG     = 3'b000,
        MD_IN_NEG_IND = 3'b001,
        MD_IN_POS     = 3'b010,
        MD_IN_POS_IND = 3'b011,
        MD_HANDSHAKE  = 3'b100,
        MD_PULSE      = 3'b101,
        MD_MAN_LO     = 3'b110,
        MD_MAN_HI     = 3'b111
    } c2_mode_t;

    function automatic c2_state_t enter_mode(input c2_mode_t md, input logic lvl);
        c2_state_t s;
        unique case (md)
            MD_MAN_LO:    s = C2_MAN_LO;
            MD_MAN_HI:    s = C2_MAN_HI;
            MD_HANDSHAKE: s = lvl ? C2_HS_HI : C2_HS_LO;
            MD_PULSE:     s = lvl ? C2_PL_HI : C2_PL_LO;
            default:      s = lvl ? C2_IN_HI : C2_IN_LO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pctl_sync.sv
module pctl_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pctl_port.sv
module pctl_port
    import pctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_q,        // current nibble
    input  logic       mode_wr,       // control register written this cycle
    input  logic [2:0] mode_new_code, // incoming nibble bits 3:1
    input  logic       port_acc,      // read or write of own data address
    input  logic       rd_clr,        // flag-clearing read
    input  logic       wr_clr,        // flag-clearing write
    input  logic       c1_s,
    input  logic       c2_s,
    input  logic       c1_clr,
    input  logic       c2_clr,
    output logic       c1_flag,
    output logic       c2_flag,
    output logic       c2_out,
    output logic       c2_oe
);
    c2_state_t st_q, st_d;
    c2_mode_t  md_new;
    logic      c1_prev, c2_prev;
    logic      c1_act, c2_act;
    logic      indep;
    logic      lvl;

    assign md_new = c2_mode_t'(mode_new_code);
    assign lvl    = st_q[0];
    assign indep  = !mode_q[3] && mode_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1_prev <= 1'b0;
            c2_prev <= 1'b0;
        end else begin
            c1_prev <= c1_s;
            c2_prev <= c2_s;
        end
    end

    always_comb begin
        c1_act = (c1_s != c1_prev) && (c1_s == mode_q[0]);
        c2_act = (c2_s != c2_prev) && !mode_q[3] && (c2_s == mode_q[2]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= C2_IN_LO;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d = enter_mode(md_new, lvl);
        end else begin
            unique case (st_q)
                C2_IN_LO, C2_IN_HI,
                C2_MAN_LO, C2_MAN_HI: st_d = st_q;
                C2_HS_LO: if (!port_acc && c1_act) st_d = C2_HS_HI;
                C2_HS_HI: if (port_acc)            st_d = C2_HS_LO;
                C2_PL_LO: if (!port_acc)           st_d = C2_PL_HI;
                C2_PL_HI: if (port_acc)            st_d = C2_PL_LO;
            endcase
        end
    end

    // outputs
    always_comb begin
        c2_oe  = mode_q[3];
        c2_out = mode_q[3] && lvl;
    end

    // edge flags: set wins over every clear source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1_flag <= 1'b0;
            c2_flag <= 1'b0;
        end else begin
            c1_flag <= c1_act || (c1_flag && !(rd_clr || wr_clr || c1_clr));
            c2_flag <= c2_act ||
                       (c2_flag && !(((rd_clr || wr_clr) && !indep) || c2_clr));
        end
    end
endmodule

// File: rtl/pctl_handshake.sv
module pctl_handshake
    import pctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        c1_in,
    input  logic [1:0]        c2_in,
    output logic [1:0]        c2_out,
    output logic [1:0]        c2_oe,
    output logic [1:0]        c1_flag,
    output logic [1:0]        c2_flag,
    input  logic [1:0]        c1_clr,
    input  logic [1:0]        c2_clr
);
    localparam int NPORT = 2;
    localparam int NIB   = 4;
    localparam int CTRL_W = NPORT * NIB;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_QUIET = ADDR_W'(ADR_PA_QUIET);

    logic [CTRL_W-1:0] pcr_q;
    logic              ctrl_wr, ctrl_rd;
    logic [NPORT-1:0]  c1_s, c2_s;

    assign ctrl_wr = bus_stb && bus_we && (bus_addr == A_CTRL);
    assign ctrl_rd = bus_stb && !bus_we && (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n)       pcr_q <= '0;
        else if (ctrl_wr) pcr_q <= bus_wdata[CTRL_W-1:0];
    end

    assign bus_rdata = ctrl_rd ? DATA_W'(pcr_q) : '0;

    pctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2*NPORT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({c2_in, c1_in}),
        .q     ({c2_s, c1_s})
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [ADDR_W-1:0] DADR = (p == 0) ? ADDR_W'(ADR_PA) : ADDR_W'(ADR_PB);
        logic acc, rdc, wrc;

        assign acc = bus_stb && (bus_addr == DADR);
        assign rdc = bus_stb && !bus_we &&
                     ((bus_addr == DADR) || ((p == 0) && (bus_addr == A_QUIET)));
        assign wrc = bus_stb && bus_we && (bus_addr == DADR);

        pctl_port u_port (
            .clk           (clk),
            .rst_n         (rst_n),
            .mode_q        (pcr_q[p*NIB +: NIB]),
            .mode_wr       (ctrl_wr),
            .mode_new_code (bus_wdata[p*NIB+1 +: 3]),
            .port_acc      (acc),
            .rd_clr        (rdc),
            .wr_clr        (wrc),
            .c1_s          (c1_s[p]),
            .c2_s          (c2_s[p]),
            .c1_clr        (c1_clr[p]),
            .c2_clr        (c2_clr[p]),
            .c1_flag       (c1_flag[p]),
            .c2_flag       (c2_flag[p]),
            .c2_out        (c2_out[p]),
            .c2_oe         (c2_oe[p])
        );
    end
endmodule

// File: rtl/pctl_handshake_chk.sv
module pctl_handshake_chk
    import pctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [7:0]        pcr_q,
    input logic [1:0]        c2_out,
    input logic [1:0]        c2_oe,
    input logic [1:0]        c1_flag,
    input logic [1:0]        c2_flag,
    input logic [1:0]        c1_clr,
    input logic [1:0]        c2_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_QUIET = ADDR_W'(ADR_PA_QUIET);

    for (genvar p = 0; p < 2; p++) begin : g_chk
        localparam logic [ADDR_W-1:0] DADR = (p == 0) ? ADDR_W'(ADR_PA) : ADDR_W'(ADR_PB);

        // R5
        manual_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_stb && bus_we && bus_addr == A_CTRL && bus_wdata[p*4+1 +: 3] == 3'b110)
            |=> (c2_oe[p] && !c2_out[p]));

        // R6
        handshake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pcr_q[p*4+1 +: 3] == 3'b100 && bus_stb && bus_addr == DADR)
            |=> !c2_out[p]);

        // R7
        pulse_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pcr_q[p*4+1 +: 3] == 3'b101 && !c2_out[p] &&
             !(bus_stb && (bus_addr == DADR || bus_addr == A_CTRL)))
            |=> c2_out[p]);

        // R13
        manual_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pcr_q[p*4+1 +: 3] == 3'b111 && bus_stb && bus_we && bus_addr == A_CTRL &&
             bus_wdata[p*4 +: 4] == pcr_q[p*4 +: 4])
            |=> ($stable(c2_out[p]) && c2_out[p]));

        // R12
        c1_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(c1_flag[p]) |->
            $past(c1_clr[p] || (bus_stb && bus_addr == DADR) ||
                  ((p == 0) && bus_stb && !bus_we && bus_addr == A_QUIET)));

        // R12
        c2_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(c2_flag[p]) |->
            $past(c2_clr[p] || (bus_stb && bus_addr == DADR) ||
                  ((p == 0) && bus_stb && !bus_we && bus_addr == A_QUIET)));
    end
endmodule

bind pctl_handshake pctl_handshake_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pcr_q     (pcr_q),
    .c2_out    (c2_out),
    .c2_oe     (c2_oe),
    .c1_flag   (c1_flag),
    .c2_flag   (c2_flag),
    .c1_clr    (c1_clr),
    .c2_clr    (c2_clr)
);

// File: tb/pctl_handshake_tb.sv
module pctl_handshake_tb;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_stb = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] c1_in = '0, c2_in = '0, c1_clr = '0, c2_clr = '0;
    logic [1:0] c2_out, c2_oe, c1_flag, c2_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pctl_handshake #(.SYNC_STAGES(SYNC), .ADDR_W(4), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .c1_in(c1_in), .c2_in(c2_in), .c2_out(c2_out), .c2_oe(c2_oe),
        .c1_flag(c1_flag), .c2_flag(c2_flag), .c1_clr(c1_clr), .c2_clr(c2_clr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the negedge after the acting edge
    task automatic access(input logic we, input logic [3:0] adr, input logic [7:0] wd,
                          output logic [7:0] rd);
        bus_stb = 1'b1; bus_we = we; bus_addr = adr; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] adr, input logic [7:0] wd);
        logic [7:0] unused_rd;
        access(1'b1, adr, wd, unused_rd);
    endtask

    task automatic rd(input logic [3:0] adr);
        logic [7:0] unused_rd;
        access(1'b0, adr, 8'h00, unused_rd);
    endtask

    task automatic settle();
        repeat (SYNC + 1) @(negedge clk);
    endtask

    task automatic clear_all();
        c1_clr = 2'b11; c2_clr = 2'b11;
        @(negedge clk);
        c1_clr = 2'b00; c2_clr = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 c1_flag", {6'b0, c1_flag}, 8'h00);
        chk("R1 c2_flag", {6'b0, c2_flag}, 8'h00);
        chk("R1 c2_oe",   {6'b0, c2_oe},   8'h00);
        chk("R1 c2_out",  {6'b0, c2_out},  8'h00);
        access(1'b0, 4'hC, 8'h00, rv);
        chk("R1 ctrl", rv, 8'h00);

        // R2 placement and readback
        wr(4'hC, 8'hA5);
        access(1'b0, 4'hC, 8'h00, rv);
        chk("R2 ctrl readback", rv, 8'hA5);
        access(1'b0, 4'h3, 8'h00, rv);
        chk("R2 other addr", rv, 8'h00);

        // sweep every nibble on both ports
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < 16; n++) begin
                logic [3:0] nb;
                nb = 4'(n);
                clear_all();
                wr(4'hC, 8'(n) << (4 * p));
                chk($sformatf("R2/R5 oe p%0d n%0h", p, n), {7'b0, c2_oe[p]}, {7'b0, nb[3]});
                chk($sformatf("R2 other oe p%0d n%0h", p, n), {7'b0, c2_oe[1-p]}, 8'h00);
                if (nb[3:1] == 3'b110)
                    chk($sformatf("R5 man lo p%0d", p), {7'b0, c2_out[p]}, 8'h00);
                if (nb[3:1] == 3'b111)
                    chk($sformatf("R5 man hi p%0d", p), {7'b0, c2_out[p]}, 8'h01);
                c1_in[p] = 1'b1; settle();
                chk($sformatf("R3 c1 rise p%0d n%0h", p, n), {7'b0, c1_flag[p]}, {7'b0, nb[0]});
                clear_all();
                c1_in[p] = 1'b0; settle();
                chk($sformatf("R3 c1 fall p%0d n%0h", p, n), {7'b0, c1_flag[p]}, {7'b0, !nb[0]});
                clear_all();
                c2_in[p] = 1'b1; settle();
                chk($sformatf("R4 c2 rise p%0d n%0h", p, n), {7'b0, c2_flag[p]},
                    {7'b0, !nb[3] && nb[2]});
                clear_all();
                c2_in[p] = 1'b0; settle();
                chk($sformatf("R4 c2 fall p%0d n%0h", p, n), {7'b0, c2_flag[p]},
                    {7'b0, !nb[3] && !nb[2]});
                clear_all();
            end
        end

        // R5 / R13 manual levels on A
        wr(4'hC, 8'h0E);
        chk("R5 A man hi", {7'b0, c2_out[0]}, 8'h01);
        wr(4'hC, 8'h0E);
        chk("R13 A repeat hi", {7'b0, c2_out[0]}, 8'h01);
        wr(4'hC, 8'h0C);
        chk("R5 A man lo", {7'b0, c2_out[0]}, 8'h00);
        wr(4'hC, 8'h0E);

        // R6 handshake on A, rising C1 active
        wr(4'hC, 8'h09);
        chk("R6 hs keeps high", {7'b0, c2_out[0]}, 8'h01);
        rd(4'hF);
        chk("R9 quiet read keeps C2", {7'b0, c2_out[0]}, 8'h01);
        rd(4'h1);
        chk("R6 read drops C2", {7'b0, c2_out[0]}, 8'h00);
        @(negedge clk);
        chk("R6 stays low", {7'b0, c2_out[0]}, 8'h00);
        c1_in[0] = 1'b1; settle();
        chk("R6 c1 edge raises C2", {7'b0, c2_out[0]}, 8'h01);
        chk("R3 hs c1 flag", {7'b0, c1_flag[0]}, 8'h01);
        wr(4'h1, 8'h00);
        chk("R6 write drops C2", {7'b0, c2_out[0]}, 8'h00);
        chk("R10 write clears c1", {7'b0, c1_flag[0]}, 8'h00);
        c1_in[0] = 1'b0; settle();
        chk("R6 inactive edge no rise", {7'b0, c2_out[0]}, 8'h00);
        chk("R3 inactive edge no flag", {7'b0, c1_flag[0]}, 8'h00);

        // same-edge: C1 edge vs port access
        c1_in[0] = 1'b1;
        repeat (SYNC) @(negedge clk);
        rd(4'h1);
        chk("R6 access beats c1 edge", {7'b0, c2_out[0]}, 8'h00);
        chk("R12 set beats read clear", {7'b0, c1_flag[0]}, 8'h01);
        c1_in[0] = 1'b0; settle();
        clear_all();

        // R8 retention
        wr(4'hC, 8'h00);
        chk("R8 input oe", {7'b0, c2_oe[0]}, 8'h00);
        chk("R8 input out", {7'b0, c2_out[0]}, 8'h00);
        wr(4'hC, 8'h08);
        chk("R8 retained low", {7'b0, c2_out[0]}, 8'h00);
        wr(4'hC, 8'h0E);
        wr(4'hC, 8'h00);
        chk("R8 input hides high", {7'b0, c2_out[0]}, 8'h00);
        wr(4'hC, 8'h08);
        chk("R8 retained high", {7'b0, c2_out[0]}, 8'h01);

        // R7 pulse on B
        wr(4'hC, 8'hE0);
        wr(4'hC, 8'hA0);
        chk("R7 pulse idle high", {7'b0, c2_out[1]}, 8'h01);
        wr(4'h0, 8'h55);
        chk("R7 write pulse low", {7'b0, c2_out[1]}, 8'h00);
        @(negedge clk);
        chk("R7 pulse back high", {7'b0, c2_out[1]}, 8'h01);
        rd(4'h0);
        chk("R7 read pulse low", {7'b0, c2_out[1]}, 8'h00);
        @(negedge clk);
        chk("R7 read pulse high", {7'b0, c2_out[1]}, 8'h01);
        wr(4'h1, 8'h00);
        chk("R7 other port no pulse", {7'b0, c2_out[1]}, 8'h01);

        // R9 / R10 / R11 flag clearing
        wr(4'hC, 8'h05);
        c1_in[0] = 1'b1; c2_in[0] = 1'b1; settle();
        chk("R3 A c1 set", {7'b0, c1_flag[0]}, 8'h01);
        chk("R4 A c2 set", {7'b0, c2_flag[0]}, 8'h01);
        wr(4'h1, 8'h00);
        chk("R10 write clears both", {6'b0, c2_flag[0], c1_flag[0]}, 8'h00);
        c1_in[0] = 1'b0; c2_in[0] = 1'b0; settle();

        wr(4'hC, 8'h07);
        c1_in[0] = 1'b1; c2_in[0] = 1'b1; settle();
        wr(4'h1, 8'h00);
        chk("R10 indep write c1", {7'b0, c1_flag[0]}, 8'h00);
        chk("R11 indep write keeps c2", {7'b0, c2_flag[0]}, 8'h01);
        rd(4'h1);
        chk("R11 indep read keeps c2", {7'b0, c2_flag[0]}, 8'h01);
        rd(4'hF);
        chk("R11 indep quiet read keeps c2", {7'b0, c2_flag[0]}, 8'h01);
        c2_clr[0] = 1'b1; @(negedge clk); c2_clr[0] = 1'b0;
        chk("R12 clr input", {7'b0, c2_flag[0]}, 8'h00);
        c1_in[0] = 1'b0; c2_in[0] = 1'b0; settle();

        wr(4'hC, 8'h55);
        c1_in = 2'b11; c2_in = 2'b11; settle();
        chk("R3/R4 all flags set", {4'b0, c2_flag, c1_flag}, 8'h0F);
        rd(4'h0);
        chk("R9 B read clears B", {6'b0, c2_flag[1], c1_flag[1]}, 8'h00);
        chk("R9 B read spares A", {6'b0, c2_flag[0], c1_flag[0]}, 8'h03);
        rd(4'hF);
        chk("R9 quiet read clears A", {6'b0, c2_flag[0], c1_flag[0]}, 8'h00);
        c1_in = 2'b00; c2_in = 2'b00; settle();
        chk("R3/R4 falling inactive", {4'b0, c2_flag, c1_flag}, 8'h00);

        // R12 set vs clear strobe on the same edge
        c2_in[0] = 1'b1;
        repeat (SYNC) @(negedge clk);
        c2_clr[0] = 1'b1; @(negedge clk); c2_clr[0] = 1'b0;
        chk("R12 set beats clr", {7'b0, c2_flag[0]}, 8'h01);
        c2_clr[0] = 1'b1; @(negedge clk); c2_clr[0] = 1'b0;
        chk("R12 later clr", {7'b0, c2_flag[0]}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule